// File: doc/BRIEF.md
# UART Interrupt Identifier

This block gathers the interrupt causes of a 16550-class serial port and reports the most urgent one as a 4-bit identification code. The causes are line errors, received data at or above the trigger level, a stale receive FIFO (character timeout), the transmit holding register going empty, and modem-line changes. Each cause has its own enable bit. Each cause is acknowledged by the register access that services it, which reaches the block as a one-cycle strobe.

A single interrupt line is raised while any enabled cause is pending. The identification code is registered. While software reads the identification register, the code is frozen, so the value read is the value the block acts on. A read of the identification register acknowledges the transmitter-empty cause only when that cause is the one being reported. The character timeout is measured in bit ticks: four character times, where the character length in bits comes from an input.

Top module: `uart_irq_ident`

## Requirements
- R1: During and just after synchronous reset, `iir` reads 0001 and `irq` is 0.
- R2: `iir` codes are: nothing pending 0001, line status 0110, receive data 0100, character timeout 1100, transmitter empty 0010, modem status 0000. Bit 0 is 0 exactly when a cause is reported. `irq` is 1 while any enabled cause is pending.
- R3: Enable bits are `ien[0]` for receive data and timeout, `ien[1]` for transmitter empty, `ien[2]` for line status, and `ien[3]` for modem status. Any bit of `line_err` latches the line-status cause, and `rd_lsr` clears it. A new event in the same cycle as the clear wins.
- R4: The receive-data cause follows the `rx_avail` level and reports only while `ien[0]` is set.
- R5: In FIFO mode, with `rx_nonempty` high and no `rx_push` or `rd_rbr` for 4×`bits_per_char` bit ticks, the timeout cause sets. `rd_rbr` clears it. `rx_push` and `rd_rbr` restart the count, and cycles without `bit_tick` do not count.
- R6: The transmitter-empty cause latches on a rising edge of `thr_empty` only while `ien[1]` is set. `wr_thr` clears it. `rd_iir` clears it only when `iir` shows 0010 during that read.
- R7: Any bit of `modem_delta` latches the modem cause, and `rd_msr` clears it.
- R8: When several causes are pending, the priority is line status, then receive data or timeout, then transmitter empty, then modem status.
- R9: In a cycle with `rd_iir` high, `iir` keeps its value at the next edge.
- R10: With `fifo_mode` low, the timeout cause never sets and `iir[3]` stays 0.
- R11: An event presented in one cycle appears on `iir` and `irq` after the second following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | FIFO mode on |
| ien | input | 4 | Per-cause enables |
| line_err | input | 4 | Overrun, parity, framing and break event pulses |
| rx_avail | input | 1 | Receive data at or above trigger level |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | Character written into receive FIFO |
| bit_tick | input | 1 | One bit time elapsed |
| bits_per_char | input | 6 | Bit times per character |
| thr_empty | input | 1 | Transmit holding register empty level |
| modem_delta | input | 4 | CTS, DSR, RI and DCD change pulses |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe (pops FIFO) |
| rd_msr | input | 1 | Modem status read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request |
| iir | output | 4 | Identification code |

## Verification
A latch that misses a set or a clear shows up at the ports as a wrong code. Within two edges, `iir` either keeps reporting a cause that software has already serviced or never reports one it should. A priority fault shows as the wrong code while several causes are pending at once. A faulty freeze or a faulty read-acknowledge of the transmitter-empty cause shows as a changed code right after a read. It can also appear later, as a lower cause that stays reported or vanishes. A timeout counter off by one tick moves the 1100 code by one cycle, and the bench samples exactly at that boundary.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] CODE_NONE = 4'b0001;
  localparam logic [3:0] CODE_LSR  = 4'b0110;
  localparam logic [3:0] CODE_RDA  = 4'b0100;
  localparam logic [3:0] CODE_TMO  = 4'b1100;
  localparam logic [3:0] CODE_THRE = 4'b0010;
  localparam logic [3:0] CODE_MSR  = 4'b0000;
  localparam int EN_RX  = 0;
  localparam int EN_TX  = 1;
  localparam int EN_LS  = 2;
  localparam int EN_MS  = 3;
endpackage

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
  parameter int BPC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             bit_tick,
  input  logic             rx_nonempty,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [BPC_W-1:0] bits_per_char,
  output logic             tmo
);
  localparam int CW = BPC_W + 2;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          idle_arm;

  assign limit    = {bits_per_char, 2'b00};
  assign idle_arm = fifo_mode && rx_nonempty;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else begin
      if (!idle_arm || rx_push || rx_pop) cnt <= '0;
      else if (bit_tick && cnt != limit) cnt <= cnt + 1'b1;
      if (!idle_arm || rx_pop) tmo <= 1'b0;
      else if (cnt == limit && limit != '0) tmo <= 1'b1;
    end
  end

  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    (rx_push || rx_pop) |=> (cnt == '0));
  a_r10_fifo_off: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |=> !tmo);
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int ERR_W = 4,
  parameter int MDM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ien,
  input  logic [ERR_W-1:0] line_err,
  input  logic             rx_avail,
  input  logic             thr_empty,
  input  logic [MDM_W-1:0] modem_delta,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             wr_thr,
  input  logic             rd_iir,
  input  logic [3:0]       iir_cur,
  output logic             pend_ls,
  output logic             pend_rx,
  output logic             pend_tx,
  output logic             pend_ms
);
  logic thr_d;
  logic tx_rise;
  logic tx_ack;

  assign tx_rise = thr_empty && !thr_d;
  assign tx_ack  = wr_thr || (rd_iir && iir_cur == CODE_THRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ls <= 1'b0;
      pend_rx <= 1'b0;
      pend_tx <= 1'b0;
      pend_ms <= 1'b0;
      thr_d   <= 1'b0;
    end else begin
      pend_ls <= (|line_err) || (pend_ls && !rd_lsr);
      pend_rx <= rx_avail;
      pend_tx <= ien[EN_TX] && (tx_rise || (pend_tx && !tx_ack));
      pend_ms <= (|modem_delta) || (pend_ms && !rd_msr);
      thr_d   <= thr_empty;
    end
  end

  a_r3_ls_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_lsr && !(|line_err)) |=> !pend_ls);
  a_r7_ms_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_msr && !(|modem_delta)) |=> !pend_ms);
  a_r6_tx_ack: assert property (@(posedge clk) disable iff (rst)
    (rd_iir && iir_cur == CODE_THRE && !tx_rise) |=> !pend_tx);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [3:0] ien,
  input  logic       pend_ls,
  input  logic       pend_rx,
  input  logic       pend_tmo,
  input  logic       pend_tx,
  input  logic       pend_ms,
  output logic [3:0] code,
  output logic       any
);
  logic ls_on, rx_on, tmo_on, tx_on, ms_on;

  assign ls_on  = pend_ls  && ien[EN_LS];
  assign rx_on  = pend_rx  && ien[EN_RX];
  assign tmo_on = pend_tmo && ien[EN_RX];
  assign tx_on  = pend_tx  && ien[EN_TX];
  assign ms_on  = pend_ms  && ien[EN_MS];
  assign any    = ls_on || rx_on || tmo_on || tx_on || ms_on;

  always_comb begin
    if (ls_on)       code = CODE_LSR;
    else if (rx_on)  code = CODE_RDA;
    else if (tmo_on) code = CODE_TMO;
    else if (tx_on)  code = CODE_THRE;
    else if (ms_on)  code = CODE_MSR;
    else             code = CODE_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int BPC_W = 6,
  parameter int ERR_W = 4,
  parameter int MDM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic [3:0]       ien,
  input  logic [ERR_W-1:0] line_err,
  input  logic             rx_avail,
  input  logic             rx_nonempty,
  input  logic             rx_push,
  input  logic             bit_tick,
  input  logic [BPC_W-1:0] bits_per_char,
  input  logic             thr_empty,
  input  logic [MDM_W-1:0] modem_delta,
  input  logic             rd_iir,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic             irq,
  output logic [3:0]       iir
);
  logic pend_ls, pend_rx, pend_tx, pend_ms, pend_tmo;
  logic [3:0] code;
  logic       any;

  uart_irq_tmo #(.BPC_W(BPC_W)) u_tmo (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .bit_tick(bit_tick),
    .rx_nonempty(rx_nonempty), .rx_push(rx_push), .rx_pop(rd_rbr),
    .bits_per_char(bits_per_char), .tmo(pend_tmo)
  );

  uart_irq_src #(.ERR_W(ERR_W), .MDM_W(MDM_W)) u_src (
    .clk(clk), .rst(rst), .ien(ien), .line_err(line_err),
    .rx_avail(rx_avail), .thr_empty(thr_empty), .modem_delta(modem_delta),
    .rd_lsr(rd_lsr), .rd_msr(rd_msr), .wr_thr(wr_thr), .rd_iir(rd_iir),
    .iir_cur(iir), .pend_ls(pend_ls), .pend_rx(pend_rx),
    .pend_tx(pend_tx), .pend_ms(pend_ms)
  );

  uart_irq_prio u_prio (
    .ien(ien), .pend_ls(pend_ls), .pend_rx(pend_rx), .pend_tmo(pend_tmo),
    .pend_tx(pend_tx), .pend_ms(pend_ms), .code(code), .any(any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir <= CODE_NONE;
      irq <= 1'b0;
    end else begin
      if (!rd_iir) iir <= code;
      irq <= any;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (iir == CODE_NONE && !irq));
  a_r9_read_hold: assert property (@(posedge clk) disable iff (rst)
    rd_iir |=> $stable(iir));
  a_r2_bit0_vs_irq: assert property (@(posedge clk) disable iff (rst)
    (!rd_iir && any) |=> !iir[0]);
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_mode = 1'b0;
  logic [3:0] ien = '0;
  logic [3:0] line_err = '0;
  logic       rx_avail = 1'b0, rx_nonempty = 1'b0, rx_push = 1'b0, bit_tick = 1'b1;
  logic [5:0] bits_per_char = 6'd2;
  logic       thr_empty = 1'b0;
  logic [3:0] modem_delta = '0;
  logic       rd_iir = 1'b0, rd_lsr = 1'b0, rd_rbr = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
  logic       irq;
  logic [3:0] iir;

  int n_chk = 0;
  int n_bad = 0;
  bit use_model = 1'b1;
  logic m_ls = 0, m_rx = 0, m_tx = 0, m_ms = 0, m_thr_d = 0;
  logic [3:0] exp_iir = 4'b0001;
  logic exp_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .ien(ien), .line_err(line_err),
    .rx_avail(rx_avail), .rx_nonempty(rx_nonempty), .rx_push(rx_push),
    .bit_tick(bit_tick), .bits_per_char(bits_per_char), .thr_empty(thr_empty),
    .modem_delta(modem_delta), .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
    .rd_msr(rd_msr), .wr_thr(wr_thr), .irq(irq), .iir(iir)
  );

  function automatic logic [3:0] code_of(logic ls, logic rx, logic tx, logic ms, logic [3:0] en);
    if (ls && en[2]) return 4'b0110;
    if (rx && en[0]) return 4'b0100;
    if (tx && en[1]) return 4'b0010;
    if (ms && en[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic step();
    logic [3:0] nc;
    logic ni, rise;
    @(posedge clk);
    if (rst) begin
      m_ls = 0; m_rx = 0; m_tx = 0; m_ms = 0; m_thr_d = 0;
      exp_iir = 4'b0001; exp_irq = 0;
    end else begin
      nc = code_of(m_ls, m_rx, m_tx, m_ms, ien);
      ni = (m_ls & ien[2]) | (m_rx & ien[0]) | (m_tx & ien[1]) | (m_ms & ien[3]);
      rise = thr_empty & ~m_thr_d;
      m_tx = ien[1] & (rise | (m_tx & ~wr_thr & ~(rd_iir && exp_iir == 4'b0010)));
      m_ls = (|line_err) | (m_ls & ~rd_lsr);
      m_ms = (|modem_delta) | (m_ms & ~rd_msr);
      m_rx = rx_avail;
      m_thr_d = thr_empty;
      if (!rd_iir) exp_iir = nc;
      exp_irq = ni;
    end
    #1;
    if (use_model) begin
      chk(iir === exp_iir, "R2 R8 iir model", iir, exp_iir);
      chk(irq === exp_irq, "R2 irq model", {3'b0, irq}, {3'b0, exp_irq});
    end
    line_err = '0; modem_delta = '0; rx_push = 0;
    rd_iir = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1; steps(2); rst = 0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk(iir === 4'b0001 && irq === 1'b0, "R1 reset state", iir, 4'b0001);

    // R11 latency and R3 line status
    ien = 4'b0100; line_err = 4'b0010;
    step(); chk(iir === 4'b0001, "R11 one edge", iir, 4'b0001);
    step(); chk(iir === 4'b0110 && irq, "R11 R3 two edges", iir, 4'b0110);
    rd_lsr = 1; steps(2); chk(iir === 4'b0001 && !irq, "R3 cleared by rd_lsr", iir, 4'b0001);

    // R4 receive data level
    ien = 4'b0001; rx_avail = 1; steps(2);
    chk(iir === 4'b0100, "R4 rx level", iir, 4'b0100);
    ien = 4'b0000; steps(2);
    chk(iir === 4'b0001 && !irq, "R4 masked", iir, 4'b0001);
    rx_avail = 0; steps(2);

    // R8 priority ladder with R7
    ien = 4'hF; line_err = 4'b1000; rx_avail = 1; thr_empty = 1; modem_delta = 4'b0100;
    steps(2); chk(iir === 4'b0110, "R8 line status first", iir, 4'b0110);
    rd_lsr = 1; steps(2); chk(iir === 4'b0100, "R8 rx second", iir, 4'b0100);
    rx_avail = 0; steps(2); chk(iir === 4'b0010, "R8 thre third", iir, 4'b0010);
    wr_thr = 1; steps(2); chk(iir === 4'b0000 && irq, "R7 modem pending", iir, 4'b0000);
    rd_msr = 1; steps(2); chk(iir === 4'b0001 && !irq, "R7 cleared by rd_msr", iir, 4'b0001);

    // R6 enable required at rising edge
    ien = 4'b0000; thr_empty = 0; step(); thr_empty = 1; step();
    ien = 4'b0010; steps(2); chk(iir === 4'b0001, "R6 rise while disabled", iir, 4'b0001);

    // R9 hold and R6 ack by identification read
    thr_empty = 0; step(); thr_empty = 1; line_err = 4'b0001; steps(2);
    chk(iir === 4'b0010, "R6 thre reported", iir, 4'b0010);
    rd_iir = 1; ien = 4'b0110; step();
    chk(iir === 4'b0010, "R9 held during read", iir, 4'b0010);
    step(); chk(iir === 4'b0110, "R8 after hold", iir, 4'b0110);
    rd_lsr = 1; steps(2); chk(iir === 4'b0001, "R6 thre acked by read", iir, 4'b0001);

    // R6 read while other source reported does not ack
    thr_empty = 0; step(); thr_empty = 1; line_err = 4'b0100; steps(2);
    chk(iir === 4'b0110, "R6 lsr over thre", iir, 4'b0110);
    rd_iir = 1; step(); rd_lsr = 1; steps(2);
    chk(iir === 4'b0010, "R6 thre survives read", iir, 4'b0010);
    wr_thr = 1; steps(2);

    // R5 timeout
    use_model = 0; do_reset();
    fifo_mode = 1; ien = 4'b0001; bits_per_char = 6'd2; bit_tick = 1; rx_nonempty = 1;
    rx_push = 1; step(); steps(9);
    chk(iir === 4'b0001, "R5 not before four chars", iir, 4'b0001);
    step(); chk(iir === 4'b1100 && irq, "R5 timeout code", iir, 4'b1100);
    rd_rbr = 1; steps(2); chk(iir === 4'b0001, "R5 cleared by rd_rbr", iir, 4'b0001);
    steps(3); rx_push = 1; step(); steps(9);
    chk(iir === 4'b0001, "R5 push restarts", iir, 4'b0001);
    step(); chk(iir === 4'b1100, "R5 after restart", iir, 4'b1100);
    rd_rbr = 1; step(); bit_tick = 0; steps(20);
    chk(iir === 4'b0001, "R5 no tick no count", iir, 4'b0001);
    bit_tick = 1;

    // R10 fifo mode off
    do_reset(); fifo_mode = 0; rx_push = 1; steps(25);
    chk(iir === 4'b0001 && !iir[3], "R10 no timeout", iir, 4'b0001);

    // random phase, model compare
    rx_nonempty = 0; do_reset(); use_model = 1;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 15) == 0) ien = 4'($urandom);
      fifo_mode   = 1'($urandom);
      line_err    = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
      modem_delta = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
      if ($urandom_range(0, 5) == 0) rx_avail = ~rx_avail;
      if ($urandom_range(0, 4) == 0) thr_empty = ~thr_empty;
      rd_iir = ($urandom_range(0, 4) == 0);
      rd_lsr = ($urandom_range(0, 6) == 0);
      rd_msr = ($urandom_range(0, 6) == 0);
      wr_thr = ($urandom_range(0, 7) == 0);
      step();
    end
    finish_run();
  end
endmodule